// File: doc/BRIEF.md
# Time-Multiplexed Byte Substitution Unit

This block applies the AES forward byte substitution to a full 128-bit state. It does not use one lookup table per byte. It owns a single 256-entry, 8-bit table with two independent synchronous read ports. A pass counter walks the state two bytes at a time: a multiplexer picks the bytes for the current pass, and the table returns the two substituted bytes one cycle later. A demultiplexer, steered by a one-cycle-delayed copy of the counter, writes those bytes back into their original positions in the output state. The price is latency, and the gain is fifteen fewer tables.

A caller presents the state on `state_i` and pulses `start_i` for one cycle. The unit captures the state on that edge. When the last pair has been written back, it raises `done_o` for one cycle. `state_o` holds the result from then until the next accepted run begins to overwrite it. The table is never written. Its contents are computed at elaboration time from the field inverse and the affine map, and the table has no write port.

Top module: `tdm_sbox_sub`

## Requirements
- R1: After reset `done_o` is 0 and `state_o` is all zero.
- R2: The input is four 32-bit words, word w = `state_i[32w+31:32w]`. Byte k (k = 0..15) is bits 8(k mod 4)+7 down to 8(k mod 4) of word k/4, which is `state_i[8k+7:8k]`. Byte k of `state_o` equals the forward S-box of byte k of the captured input, for example 0x00 gives 0x63, 0x53 gives 0xED, 0x01 gives 0x7C and 0xFF gives 0x16.
- R3: `done_o` goes high exactly 9 clock edges after the edge that accepts `start_i`, one edge per pass plus one for the table read. It stays high for exactly one cycle.
- R4: A `start_i` pulse seen on any edge from the accepting edge up to and including the 8th edge after it is ignored. The result and the timing of `done_o` are those of the first run.
- R5: `state_o` keeps the previous result unchanged until the 2nd edge after the next accepted start. No byte changes outside a run.
- R6: `state_i` is sampled only on the accepting edge. Changing it during a run has no effect on the result.
- R7: Every one of the 256 byte values is substituted correctly, in any of the 16 byte positions it is presented in.
- R8: A `start_i` seen on the edge that raises `done_o` (the 9th edge) is accepted, so runs may follow back to back every 9 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse to begin a substitution run |
| state_i | input | 128 | State to substitute, four 32-bit words |
| done_o | output | 1 | One-cycle pulse when `state_o` holds a new result |
| state_o | output | 128 | Substituted state |

## Verification
Two cases are the hardest to reach from the ports. One is a start request that lands inside a run. The other is a new run that starts while the previous result is still the only copy on `state_o`. The stimulus pulses `start_i` with different data mid-run, and rewrites `state_i` right after acceptance, then checks that the result and the done edge belong to the first run. It also issues a start on the very cycle `done_o` is high, and samples `state_o` on the following cycle to see that the old result survives the first pass of the new run. A 16-run sweep puts every byte value into a rotating position, so each of the 256 table entries is read.

// File: rtl/tdm_sbox_pkg.sv
package tdm_sbox_pkg;

   localparam int BYTE_W      = 8;
   localparam int TABLE_DEPTH = 1 << BYTE_W;

   // GF(2^8) product modulo x^8+x^4+x^3+x+1
   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc;
      logic [7:0] sh;
      acc = 8'h00;
      sh  = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ sh;
         sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1b : 8'h00);
      end
      return acc;
   endfunction

   // multiplicative inverse as a^254 (0 maps to 0)
   function automatic logic [7:0] gf_inv(input logic [7:0] a);
      logic [7:0] r;
      logic [7:0] e;
      r = 8'h01;
      e = 8'd254;
      for (int i = 7; i >= 0; i--) begin
         r = gf_mul(r, r);
         if (e[i]) r = gf_mul(r, a);
      end
      return r;
   endfunction

   function automatic logic [7:0] sbox_fwd(input logic [7:0] x);
      logic [7:0] b;
      b = gf_inv(x);
      return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
               ^ {b[3:0], b[7:4]} ^ 8'h63;
   endfunction

endpackage

// File: rtl/tdm_sbox_rom.sv
module tdm_sbox_rom #(
   parameter int LANES = 2
) (
   input  logic                                       clk,
   input  logic [LANES-1:0][tdm_sbox_pkg::BYTE_W-1:0] addr_i,
   output logic [LANES-1:0][tdm_sbox_pkg::BYTE_W-1:0] data_o
);
   import tdm_sbox_pkg::*;

   if (LANES < 1) begin : g_bad_lanes
      $error("tdm_sbox_rom: LANES must be at least 1");
   end

   logic [BYTE_W-1:0] table_q [TABLE_DEPTH];

   for (genvar e = 0; e < TABLE_DEPTH; e++) begin : g_entry
      assign table_q[e] = sbox_fwd(BYTE_W'(e));
   end

   for (genvar l = 0; l < LANES; l++) begin : g_port
      always_ff @(posedge clk) begin
         data_o[l] <= table_q[addr_i[l]];
      end
   end

endmodule

// File: rtl/tdm_sbox_ctrl.sv
module tdm_sbox_ctrl #(
   parameter int PASSES = 8,
   localparam int PASS_W = (PASSES > 1) ? $clog2(PASSES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              accept_o,
   output logic [PASS_W-1:0] pass_o,
   output logic              wr_vld_o,
   output logic [PASS_W-1:0] wr_pass_o,
   output logic              done_o
);
   localparam logic [PASS_W-1:0] LAST = PASS_W'(PASSES - 1);

   if (PASSES < 2) begin : g_bad_passes
      $error("tdm_sbox_ctrl: PASSES must be at least 2");
   end

   logic              busy_q;
   logic [PASS_W-1:0] pass_q;

   assign accept_o = start_i && !busy_q;
   assign pass_o   = pass_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         pass_q <= '0;
      end else if (accept_o) begin
         busy_q <= 1'b1;
         pass_q <= '0;
      end else if (busy_q) begin
         if (pass_q == LAST) busy_q <= 1'b0;
         else                pass_q <= pass_q + 1'b1;
      end
   end

   // table read takes one cycle: delay pass index to steer the write-back
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_vld_o  <= 1'b0;
         wr_pass_o <= '0;
         done_o    <= 1'b0;
      end else begin
         wr_vld_o  <= busy_q;
         wr_pass_o <= pass_q;
         done_o    <= wr_vld_o && (wr_pass_o == LAST);
      end
   end

   a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r3_accept_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      accept_o |=> (pass_q == '0) && wr_vld_o == $past(busy_q));

   a_r4_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && busy_q && pass_q != LAST) |=>
         (busy_q && pass_q == PASS_W'($past(pass_q) + 1'b1)));

   a_r3_done_after_last_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_vld_o && wr_pass_o == LAST) |=> done_o);

endmodule

// File: rtl/tdm_sbox_scatter.sv
module tdm_sbox_scatter #(
   parameter int BYTES = 16,
   parameter int LANES = 2,
   localparam int PASSES = BYTES / LANES,
   localparam int PASS_W = (PASSES > 1) ? $clog2(PASSES) : 1
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic                                       wr_vld_i,
   input  logic [PASS_W-1:0]                          wr_pass_i,
   input  logic [LANES-1:0][tdm_sbox_pkg::BYTE_W-1:0] lane_i,
   output logic [BYTES*tdm_sbox_pkg::BYTE_W-1:0]      state_o
);
   import tdm_sbox_pkg::*;

   if (BYTES % LANES != 0) begin : g_bad_split
      $error("tdm_sbox_scatter: BYTES must be a multiple of LANES");
   end

   for (genvar j = 0; j < BYTES; j++) begin : g_byte
      localparam int P = j / LANES;
      localparam int L = j % LANES;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            state_o[j*BYTE_W +: BYTE_W] <= '0;
         else if (wr_vld_i && wr_pass_i == PASS_W'(P))
            state_o[j*BYTE_W +: BYTE_W] <= lane_i[L];
      end
   end

   a_r5_idle_output_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_vld_i |=> $stable(state_o));

endmodule

// File: rtl/tdm_sbox_sub.sv
module tdm_sbox_sub #(
   parameter int STATE_W = 128,
   parameter int WORD_W  = 32,
   parameter int LANES   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [STATE_W-1:0] state_i,
   output logic               done_o,
   output logic [STATE_W-1:0] state_o
);
   import tdm_sbox_pkg::*;

   localparam int BYTES    = STATE_W / BYTE_W;
   localparam int PER_WORD = WORD_W / BYTE_W;
   localparam int WORDS    = STATE_W / WORD_W;
   localparam int PASSES   = BYTES / LANES;
   localparam int PASS_W   = (PASSES > 1) ? $clog2(PASSES) : 1;

   if (STATE_W % WORD_W != 0) begin : g_bad_word
      $error("tdm_sbox_sub: STATE_W must be a multiple of WORD_W");
   end
   if (WORD_W % BYTE_W != 0) begin : g_bad_byte
      $error("tdm_sbox_sub: WORD_W must be a multiple of 8");
   end
   if (BYTES % LANES != 0 || PASSES < 2) begin : g_bad_lanes
      $error("tdm_sbox_sub: LANES must divide the byte count into at least two passes");
   end

   logic                           accept;
   logic [PASS_W-1:0]              pass;
   logic                           wr_vld;
   logic [PASS_W-1:0]              wr_pass;
   logic [STATE_W-1:0]             hold_q;
   logic [BYTES-1:0][BYTE_W-1:0]   src_bytes;
   logic [LANES-1:0][BYTE_W-1:0]   rd_addr;
   logic [LANES-1:0][BYTE_W-1:0]   rd_data;

   tdm_sbox_ctrl #(.PASSES(PASSES)) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .accept_o  (accept),
      .pass_o    (pass),
      .wr_vld_o  (wr_vld),
      .wr_pass_o (wr_pass),
      .done_o    (done_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hold_q <= '0;
      else if (accept) hold_q <= state_i;
   end

   // slice bytes out of each word
   for (genvar w = 0; w < WORDS; w++) begin : g_word
      for (genvar b = 0; b < PER_WORD; b++) begin : g_slice
         assign src_bytes[w*PER_WORD + b] = hold_q[w*WORD_W + b*BYTE_W +: BYTE_W];
      end
   end

   // pass-driven selector: pass p feeds bytes p*LANES .. p*LANES+LANES-1
   for (genvar l = 0; l < LANES; l++) begin : g_sel
      always_comb begin
         rd_addr[l] = '0;
         for (int p = 0; p < PASSES; p++) begin
            if (pass == PASS_W'(p)) rd_addr[l] = src_bytes[p*LANES + l];
         end
      end
   end

   tdm_sbox_rom #(.LANES(LANES)) rom_i (
      .clk    (clk),
      .addr_i (rd_addr),
      .data_o (rd_data)
   );

   tdm_sbox_scatter #(.BYTES(BYTES), .LANES(LANES)) scatter_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_vld_i  (wr_vld),
      .wr_pass_i (wr_pass),
      .lane_i    (rd_data),
      .state_o   (state_o)
   );

   a_r6_capture_only_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(hold_q));

   a_r5_result_stable_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> $stable(state_o));

endmodule

// File: tb/tdm_sbox_sub_tb.sv
`timescale 1ns/1ps
module tdm_sbox_sub_tb_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [127:0] state_i = '0;
   logic         done_o;
   logic [127:0] state_o;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   tdm_sbox_sub dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .state_i (state_i),
      .done_o  (done_o),
      .state_o (state_o)
   );

   // independent reference: xtime multiply, brute-force inverse, bitwise affine
   function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] r = 0;
      logic [7:0] t = b;
      for (int i = 0; i < 8; i++) begin
         if (a[i]) r ^= t;
         t = t[7] ? ((t << 1) ^ 8'h1b) : (t << 1);
      end
      return r;
   endfunction

   function automatic logic [7:0] ref_sub(input logic [7:0] x);
      logic [7:0] inv = 0;
      logic [7:0] y;
      logic [7:0] c = 8'h63;
      for (int v = 1; v < 256; v++)
         if (x != 0 && ref_mul(x, 8'(v)) == 8'h01) inv = 8'(v);
      for (int i = 0; i < 8; i++)
         y[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
      return y;
   endfunction

   function automatic logic [127:0] ref_state(input logic [127:0] s);
      logic [127:0] r;
      for (int k = 0; k < 16; k++) r[8*k +: 8] = ref_sub(s[8*k +: 8]);
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   typedef struct packed { logic [127:0] din; logic [127:0] dout; } vec_t;
   localparam vec_t VECS [5] = '{
      '{128'h0,                 {16{8'h63}}},
      '{{16{8'h53}},            {16{8'hED}}},
      '{{16{8'h01}},            {16{8'h7C}}},
      '{{16{8'hFF}},            {16{8'h16}}},
      '{{8{8'h00, 8'h53}},      {8{8'h63, 8'hED}}}
   };

   // full run: start at one negedge, check done on each of the next 9 edges.
   // mid_start: extra start pulse at edge index 3 (and 8); rewrite: change state_i after accept.
   task automatic run(input logic [127:0] din, input logic [127:0] exp, input string req,
                      input bit mid_start, input bit rewrite);
      @(negedge clk);
      start_i = 1'b1;
      state_i = din;
      @(negedge clk);
      start_i = 1'b0;
      if (rewrite) state_i = ~din;
      for (int c = 1; c <= 9; c++) begin
         if (mid_start && (c == 3 || c == 8)) begin
            start_i = 1'b1;
            state_i = din ^ 128'h5a5a;
         end
         @(negedge clk);
         start_i = 1'b0;
         chk(done_o == (c == 9), {req, " done timing"}, 128'(done_o), 128'(c == 9));
      end
      chk(state_o == exp, {req, " result"}, state_o, exp);
      @(negedge clk);
      chk(done_o == 1'b0, {req, " R3 done single cycle"}, 128'(done_o), 128'h0);
      chk(state_o == exp, {req, " R5 result held"}, state_o, exp);
   endtask

   initial begin
      logic [127:0] a;
      logic [127:0] b;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(done_o == 1'b0, "R1 done after reset", 128'(done_o), 128'h0);
      chk(state_o == '0, "R1 state after reset", state_o, 128'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 vector table
      foreach (VECS[i]) begin
         chk(ref_state(VECS[i].din) == VECS[i].dout, "R2 reference vs table",
             ref_state(VECS[i].din), VECS[i].dout);
         run(VECS[i].din, VECS[i].dout, "R2 R3", 1'b0, 1'b0);
      end

      // R7: all 256 values, rotated through positions
      for (int r = 0; r < 16; r++) begin
         logic [127:0] s;
         for (int k = 0; k < 16; k++) s[8*k +: 8] = 8'(16*r + ((k + r) % 16));
         run(s, ref_state(s), "R7 sweep", 1'b0, 1'b0);
      end

      // R4 ignored start mid-run
      a = 128'h0123456789abcdef_fedcba9876543210;
      run(a, ref_state(a), "R4 start while busy", 1'b1, 1'b0);

      // R6 input change after capture
      b = 128'h00112233_44556677_8899aabb_ccddeeff;
      run(b, ref_state(b), "R6 input change", 1'b0, 1'b1);

      // R8 back-to-back with R5 old result survives first pass
      @(negedge clk);
      start_i = 1'b1;
      state_i = a;
      @(negedge clk);
      start_i = 1'b0;
      for (int c = 1; c <= 8; c++) @(negedge clk);
      start_i = 1'b1;
      state_i = b;
      @(negedge clk);
      start_i = 1'b0;
      chk(done_o == 1'b1, "R8 first done", 128'(done_o), 128'h1);
      chk(state_o == ref_state(a), "R8 first result", state_o, ref_state(a));
      @(negedge clk);
      chk(state_o == ref_state(a), "R5 old result during pass one", state_o, ref_state(a));
      for (int c = 2; c <= 9; c++) begin
         @(negedge clk);
         chk(done_o == (c == 9), "R8 second done timing", 128'(done_o), 128'(c == 9));
      end
      chk(state_o == ref_state(b), "R8 second result", state_o, ref_state(b));

      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule